// File: doc/BRIEF.md
# Program Sequencer with Return Stack

This unit holds the program counter of a small 8-bit core and picks the address of the next instruction. On every enabled clock it takes a flow command from the decoder, a condition code, the carry and zero flags and a 12-bit target address. It then advances, branches, enters a subroutine or returns from one.

Subroutine entry saves the address of the calling instruction on a 30-entry hardware stack. A return takes that saved address and adds one to it, so execution resumes after the call. Jumps, calls and returns can each depend on the carry or zero flag. When the condition fails, the command behaves as a plain advance and leaves the stack alone. General registers and scratchpad memory are not saved on a call; software saves them.

A push onto a full stack and a pop from an empty one are reported on two status outputs. Neither one disturbs the stack level or the stored entries.

Top module: `flow_sequencer`

## Requirements
- R1: While reset is held low and on the first cycle after it is released, pc_o is 0x000, stk_level_o is 0, and both ovf_o and unf_o are 0.
- R2: Command code 0 (advance) sets pc_o to pc_o+1 whatever the condition code is, and the count wraps from 0xFFF to 0x000.
- R3: Command code 1 (branch) with a holding condition loads pc_o with target_i one cycle later.
- R4: Condition code 0 always holds. Codes 1 and 2 hold when carry_i is 1 and 0. Codes 3 and 4 hold when zero_i is 1 and 0. Codes 5 to 7 never hold. A branch, call or return whose condition fails sets pc_o to pc_o+1 and leaves stk_level_o unchanged.
- R5: Command code 2 (call) with a holding condition and fewer than 30 entries on the stack saves the current pc_o on the stack, raises stk_level_o by one and loads pc_o with target_i.
- R6: Command code 3 (return) with a holding condition and a non-empty stack sets pc_o to the most recently saved address plus one and lowers stk_level_o by one, so nested calls unwind in last-in-first-out order.
- R7: A call whose condition holds while 30 entries are stored loads pc_o with target_i and keeps stk_level_o at 30. It raises ovf_o for that update. The 30 stored entries remain intact.
- R8: A return whose condition holds while the stack is empty sets pc_o to pc_o+1 and keeps stk_level_o at 0. It raises unf_o for that update.
- R9: While en is 0, pc_o, stk_level_o, ovf_o and unf_o hold their values, whatever the command inputs are.
- R10: ovf_o and unf_o each describe only the latest enabled update. Any enabled update that is not itself a fault clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Update enable; 0 stalls the unit |
| cmd_i | input | 2 | Flow command: 0 advance, 1 branch, 2 call, 3 return |
| cond_i | input | 3 | Condition code, see R4 |
| carry_i | input | 1 | Carry flag from the ALU |
| zero_i | input | 1 | Zero flag from the ALU |
| target_i | input | 12 | Branch or call destination |
| pc_o | output | 12 | Address of the instruction to fetch |
| stk_level_o | output | 5 | Number of saved return addresses (0 to 30) |
| ovf_o | output | 1 | Last update was a call on a full stack |
| unf_o | output | 1 | Last update was a return on an empty stack |

## Verification
Most internal faults show on pc_o in the cycle right after the faulty update. A wrong condition decode or a wrong increment appears as a wrong address at once. A mistake in the stack contents, however, stays hidden until the matching return, which may come many updates later. For that reason the bench fills the stack to its limit and checks every address during the full unwind. A level counter that slips past 30 or below 0 shows at once on stk_level_o. It also shows at the next call or return as a missing fault flag or a wrong return address.

// File: rtl/seq_pkg.sv
package seq_pkg;

  localparam logic [1:0] FC_NEXT = 2'd0;
  localparam logic [1:0] FC_JUMP = 2'd1;
  localparam logic [1:0] FC_CALL = 2'd2;
  localparam logic [1:0] FC_RET  = 2'd3;

  localparam logic [2:0] CC_ALWAYS = 3'd0;
  localparam logic [2:0] CC_CSET   = 3'd1;
  localparam logic [2:0] CC_CCLR   = 3'd2;
  localparam logic [2:0] CC_ZSET   = 3'd3;
  localparam logic [2:0] CC_ZCLR   = 3'd4;

  // Codes 5 to 7 are unused and never hold.
  function automatic logic cond_holds(input logic [2:0] cc, input logic cy, input logic zf);
    case (cc)
      CC_ALWAYS: cond_holds = 1'b1;
      CC_CSET:   cond_holds = cy;
      CC_CCLR:   cond_holds = ~cy;
      CC_ZSET:   cond_holds = zf;
      CC_ZCLR:   cond_holds = ~zf;
      default:   cond_holds = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/seq_cond_unit.sv
module seq_cond_unit
  import seq_pkg::*;
(
  input  logic [2:0] cc_i,
  input  logic       carry_i,
  input  logic       zero_i,
  output logic       hold_o
);

  assign hold_o = cond_holds(cc_i, carry_i, zero_i);

  // R4
  cond_undef_chk: assert final ((cc_i <= CC_ZCLR) || !hold_o);

endmodule

// File: rtl/seq_ret_stack.sv
module seq_ret_stack #(
  parameter int ADDR_W = 12,
  parameter int DEPTH  = 30,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic [ADDR_W-1:0] push_addr_i,
  output logic [ADDR_W-1:0] top_o,
  output logic [LVL_W-1:0]  level_o,
  output logic              full_o,
  output logic              empty_o
);

  localparam logic [LVL_W-1:0] LVL_MAX = LVL_W'(DEPTH);

  logic [ADDR_W-1:0] slots [DEPTH];
  logic [LVL_W-1:0]  level_q;
  logic [LVL_W-1:0]  top_idx;

  assign full_o  = (level_q == LVL_MAX);
  assign empty_o = (level_q == '0);
  assign top_idx = level_q - LVL_W'(1);
  assign top_o   = empty_o ? '0 : slots[top_idx];
  assign level_o = level_q;

  always_ff @(posedge clk) begin
    if (push_i) slots[level_q] <= push_addr_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      level_q <= '0;
    else if (push_i) level_q <= level_q + LVL_W'(1);
    else if (pop_i)  level_q <= level_q - LVL_W'(1);
  end

  // R5
  stk_push_room_chk: assert property (@(posedge clk) disable iff (!rst_n) push_i |-> !full_o);
  // R6
  stk_pop_data_chk: assert property (@(posedge clk) disable iff (!rst_n) pop_i |-> !empty_o);
  // R6
  stk_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(push_i && pop_i));
  // R7
  stk_bound_chk: assert property (@(posedge clk) disable iff (!rst_n) level_q <= LVL_MAX);
  // R5
  stk_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |=> level_q == $past(level_q) + LVL_W'(1));

endmodule

// File: rtl/flow_sequencer.sv
module flow_sequencer
  import seq_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DEPTH  = 30,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [1:0]        cmd_i,
  input  logic [2:0]        cond_i,
  input  logic              carry_i,
  input  logic              zero_i,
  input  logic [ADDR_W-1:0] target_i,
  output logic [ADDR_W-1:0] pc_o,
  output logic [LVL_W-1:0]  stk_level_o,
  output logic              ovf_o,
  output logic              unf_o
);

  function automatic logic [ADDR_W-1:0] pc_step(input logic [ADDR_W-1:0] a);
    pc_step = a + ADDR_W'(1);
  endfunction

  logic [ADDR_W-1:0] pc_q, pc_nxt, top_addr;
  logic              cond_ok, taken;
  logic              is_jump, is_call, is_ret;
  logic              stk_full, stk_empty;
  logic              do_push, do_pop, push_blocked, pop_blocked;

  seq_cond_unit u_cond (
    .cc_i    (cond_i),
    .carry_i (carry_i),
    .zero_i  (zero_i),
    .hold_o  (cond_ok)
  );

  assign is_jump = (cmd_i == FC_JUMP);
  assign is_call = (cmd_i == FC_CALL);
  assign is_ret  = (cmd_i == FC_RET);
  assign taken   = en && cond_ok && (cmd_i != FC_NEXT);

  assign do_push      = taken && is_call && !stk_full;
  assign push_blocked = taken && is_call && stk_full;
  assign do_pop       = taken && is_ret && !stk_empty;
  assign pop_blocked  = taken && is_ret && stk_empty;

  seq_ret_stack #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_stack (
    .clk         (clk),
    .rst_n       (rst_n),
    .push_i      (do_push),
    .pop_i       (do_pop),
    .push_addr_i (pc_q),
    .top_o       (top_addr),
    .level_o     (stk_level_o),
    .full_o      (stk_full),
    .empty_o     (stk_empty)
  );

  always_comb begin
    pc_nxt = pc_step(pc_q);
    if (taken && (is_jump || is_call)) pc_nxt = target_i;
    else if (do_pop)                   pc_nxt = pc_step(top_addr);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q  <= '0;
      ovf_o <= 1'b0;
      unf_o <= 1'b0;
    end else if (en) begin
      pc_q  <= pc_nxt;
      ovf_o <= push_blocked;
      unf_o <= pop_blocked;
    end
  end

  assign pc_o = pc_q;

  // R3
  jump_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (taken && is_jump) |=> pc_o == $past(target_i));
  // R6
  ret_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    do_pop |=> pc_o == $past(top_addr) + ADDR_W'(1));
  // R4
  fail_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && cmd_i != FC_NEXT && !cond_ok) |=> (pc_o == $past(pc_o) + ADDR_W'(1)) && $stable(stk_level_o));
  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_blocked |=> ovf_o && $stable(stk_level_o) && pc_o == $past(target_i));
  // R8
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop_blocked |=> unf_o && stk_level_o == '0);
  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(pc_o) && $stable(stk_level_o) && $stable(ovf_o) && $stable(unf_o));
  // R10
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(ovf_o && unf_o));

endmodule

// File: tb/flow_sequencer_test.sv
module flow_sequencer_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [1:0]  cmd_i = 2'd0;
  logic [2:0]  cond_i = 3'd0;
  logic        carry_i = 1'b0;
  logic        zero_i = 1'b0;
  logic [11:0] target_i = 12'h000;
  logic [11:0] pc_o;
  logic [4:0]  stk_level_o;
  logic        ovf_o, unf_o;

  int total = 0;
  int bad = 0;

  logic [11:0] e_pc;
  int          e_lvl;
  logic        e_ovf, e_unf;
  logic [11:0] e_stk [30];

  always #2.5 clk = ~clk;

  flow_sequencer uut (
    .clk(clk), .rst_n(rst_n), .en(en), .cmd_i(cmd_i), .cond_i(cond_i),
    .carry_i(carry_i), .zero_i(zero_i), .target_i(target_i),
    .pc_o(pc_o), .stk_level_o(stk_level_o), .ovf_o(ovf_o), .unf_o(unf_o)
  );

  task automatic check(input string rq, input string what, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, got, exp);
    end
  endtask

  task automatic check_all(input string rq);
    check(rq, "pc", int'(pc_o), int'(e_pc));
    check(rq, "level", int'(stk_level_o), e_lvl);
    check(rq, "ovf", int'(ovf_o), int'(e_ovf));
    check(rq, "unf", int'(unf_o), int'(e_unf));
  endtask

  // Expected outcome written from the requirement text.
  task automatic step(input logic [1:0] c, input logic [2:0] cc, input logic [11:0] tgt,
                      input logic cy, input logic zf, input logic en_v, input string rq);
    logic ok;
    @(negedge clk);
    cmd_i = c; cond_i = cc; target_i = tgt; carry_i = cy; zero_i = zf; en = en_v;
    case (cc)
      3'd0: ok = 1'b1;
      3'd1: ok = (cy == 1'b1);
      3'd2: ok = (cy == 1'b0);
      3'd3: ok = (zf == 1'b1);
      3'd4: ok = (zf == 1'b0);
      default: ok = 1'b0;
    endcase
    if (en_v) begin
      e_ovf = 1'b0;
      e_unf = 1'b0;
      if (c == 2'd0 || !ok) e_pc = e_pc + 12'd1;
      else if (c == 2'd1) e_pc = tgt;
      else if (c == 2'd2) begin
        if (e_lvl == 30) e_ovf = 1'b1;
        else begin e_stk[e_lvl] = e_pc; e_lvl++; end
        e_pc = tgt;
      end else begin
        if (e_lvl == 0) begin e_unf = 1'b1; e_pc = e_pc + 12'd1; end
        else begin e_lvl--; e_pc = e_stk[e_lvl] + 12'd1; end
      end
    end
    @(posedge clk);
    #1;
    check_all(rq);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; en = 1'b1; cmd_i = 2'd1; target_i = 12'h5A5;
    repeat (3) @(posedge clk);
    #1;
    e_pc = 12'h000; e_lvl = 0; e_ovf = 1'b0; e_unf = 1'b0;
    check_all("R1");
    @(negedge clk);
    en = 1'b0; rst_n = 1'b1;
    @(posedge clk); #1;
    check_all("R1");
  endtask

  task automatic t_advance;
    step(2'd0, 3'd0, 12'h777, 0, 0, 1, "R2");
    step(2'd0, 3'd6, 12'h777, 1, 1, 1, "R2");
    step(2'd1, 3'd0, 12'hFFE, 0, 0, 1, "R3");
    step(2'd0, 3'd0, 12'h000, 0, 0, 1, "R2");
    step(2'd0, 3'd0, 12'h000, 0, 0, 1, "R2");
  endtask

  task automatic t_conditions;
    for (int cc = 0; cc < 8; cc++)
      for (int f = 0; f < 4; f++)
        step(2'd1, 3'(cc), 12'h100 + 12'(cc * 4 + f), f[0], f[1], 1, "R4");
    step(2'd2, 3'd1, 12'h300, 0, 0, 1, "R4");
    step(2'd2, 3'd7, 12'h300, 1, 1, 1, "R4");
    step(2'd3, 3'd3, 12'h000, 0, 0, 1, "R4");
  endtask

  task automatic t_nesting;
    step(2'd2, 3'd0, 12'h400, 0, 0, 1, "R5");
    step(2'd0, 3'd0, 12'h000, 0, 0, 1, "R5");
    step(2'd2, 3'd2, 12'h500, 0, 0, 1, "R5");
    step(2'd2, 3'd4, 12'h600, 0, 0, 1, "R5");
    step(2'd3, 3'd3, 12'h000, 0, 1, 1, "R6");
    step(2'd0, 3'd0, 12'h000, 0, 0, 1, "R6");
    step(2'd3, 3'd1, 12'h000, 1, 0, 1, "R6");
    step(2'd3, 3'd0, 12'h000, 0, 0, 1, "R6");
  endtask

  task automatic t_fill_and_drain;
    for (int i = 0; i < 30; i++)
      step(2'd2, 3'd0, 12'h800 + 12'(i * 16), 0, 0, 1, "R5");
    step(2'd2, 3'd0, 12'hABC, 0, 0, 1, "R7");
    step(2'd0, 3'd0, 12'h000, 0, 0, 1, "R10");
    step(2'd2, 3'd0, 12'hBCD, 0, 0, 1, "R7");
    for (int i = 0; i < 30; i++)
      step(2'd3, 3'd0, 12'h000, 0, 0, 1, "R7");
    step(2'd3, 3'd0, 12'h000, 0, 0, 1, "R8");
    step(2'd3, 3'd2, 12'h000, 0, 0, 1, "R8");
    step(2'd1, 3'd0, 12'h222, 0, 0, 1, "R10");
  endtask

  task automatic t_stall;
    step(2'd2, 3'd0, 12'h900, 0, 0, 1, "R5");
    step(2'd2, 3'd0, 12'h111, 0, 0, 0, "R9");
    step(2'd3, 3'd0, 12'h111, 0, 0, 0, "R9");
    step(2'd3, 3'd0, 12'h000, 0, 0, 1, "R6");
    step(2'd3, 3'd0, 12'h000, 0, 0, 1, "R8");
    step(2'd1, 3'd0, 12'h333, 0, 0, 0, "R9");
    step(2'd0, 3'd0, 12'h000, 0, 0, 1, "R10");
  endtask

  initial begin
    t_reset();
    t_advance();
    t_conditions();
    t_nesting();
    t_fill_and_drain();
    t_stall();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(5 * 200000);
    total++;
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule